// File: doc/BRIEF.md
# Timer Interrupt and Event Router

This block sits next to a general-purpose timer counter and collects the counter's internal events into a raw interrupt status register. The events are the counter hitting zero, the counter hitting its target, and one capture/compare event per channel. From that status register it drives three outputs. The first is a level interrupt request, gated by a mask. The other two are single-cycle pulses, an ADC trigger and a DMA request, and each follows one status bit picked by a routing field.

The block also decodes a small register bus and applies the side effects of register access. Reading or writing a channel's compare/capture register, or its preload copy, drops that channel's status flag. Touching the target or preload-target register drops both the zero and the target flags. Each of these registers has a no-clear alias that leaves the status alone. Software can then clear or force status bits explicitly. The contents of the timer data registers belong to the datapath. This block only sees the accesses to them, and reads of those addresses return zero here.

Top module: `tmr_evt_router`

## Requirements
- R1: `irq` is high exactly when some bit of the raw status AND the mask register (address 0) is set. It follows the status and mask values that result from the same clock edge.
- R2: `adc_trig` is a one-cycle pulse that appears in the cycle where the status bit selected by route bits [2:0] (address 5) goes from 0 to 1. Select values 6 and 7 disable it, and the field resets to 7.
- R3: `dma_req` behaves the same way, following the status bit selected by route bits [6:4]. That field also resets to 7.
- R4: A read or write of the compare register of channel c (address 16+c) or of its preload copy (address 20+c) clears status bit 2+c. Status layout: bit 0 zero, bit 1 target, bits 2..5 channels 0..3.
- R5: A read or write of the target register (address 8) or of the preload-target register (address 9) clears status bits 0 and 1 together.
- R6: Accesses to the no-clear aliases change no status bit. These aliases are address 10 (target), address 11 (preload target), 24+c (compare) and 28+c (preload compare).
- R7: A high `cnt_at_zero` or `cnt_at_tgt` sampled at one edge sets status bit 0 or 1 at the following edge.
- R8: A high `ch_evt[c]` sampled at an edge sets status bit 2+c at that same edge.
- R9: A `cnt_at_zero` sampled together with `tmr_start` never sets status bit 0.
- R10: Writing to the clear register (address 3) clears every status bit whose data bit is 1.
- R11: Writing to the set register (address 4) sets every status bit whose data bit is 1.
- R12: If an event or a set-register bit and any clear (side effect or clear register) reach the same status bit in the same cycle, the bit ends up set.
- R13: A read returns its value on `bus_rdata` in the next cycle, taken from the state before that edge. Address 0 returns the mask, 1 the raw status, 2 the raw status AND the mask, and 5 the route fields. Every other address returns 0, and `bus_rdata` is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_at_zero | input | 1 | Counter equals zero this cycle |
| cnt_at_tgt | input | 1 | Counter equals target this cycle |
| tmr_start | input | 1 | Timer is being started this cycle |
| ch_evt | input | NCH | Per-channel capture/compare event pulses |
| bus_sel | input | 1 | Register bus select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after the read |
| irq | output | 1 | Masked interrupt request |
| adc_trig | output | 1 | ADC trigger pulse |
| dma_req | output | 1 | DMA request pulse |

## Verification
The bench goes after collisions: an event and a side-effect clear landing on the same bit in the same cycle. A design with the wrong priority loses the event, and a later readback shows the bit at 0. It times the delayed zero/target flags by reading the status in the two cycles after the counter input. A design with no delay, or with two cycles of delay, shows the flag one cycle early or one cycle late. It also starts the timer at zero, where a design without suppression raises a spurious zero flag. It accesses the no-clear aliases and checks that they clear nothing, while the plain aliases must clear exactly their own bits. Finally, it moves the ADC and DMA routes across bits so that a pulse from the wrong bit, or a pulse held longer than one cycle, shows up at the outputs.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int AW = 5;

  // register word addresses
  localparam logic [AW-1:0] A_MASK    = 5'd0;
  localparam logic [AW-1:0] A_RAW     = 5'd1;
  localparam logic [AW-1:0] A_MIS     = 5'd2;
  localparam logic [AW-1:0] A_ICLR    = 5'd3;
  localparam logic [AW-1:0] A_ISET    = 5'd4;
  localparam logic [AW-1:0] A_ROUTE   = 5'd5;
  localparam logic [AW-1:0] A_TGT     = 5'd8;
  localparam logic [AW-1:0] A_PTGT    = 5'd9;
  localparam logic [AW-1:0] A_TGT_NC  = 5'd10;
  localparam logic [AW-1:0] A_PTGT_NC = 5'd11;
  localparam int            CC_BASE   = 16;
  localparam int            PCC_BASE  = 20;
  localparam int            CCNC_BASE = 24;
  localparam int            PCCNC_BASE = 28;

  // status bit layout
  localparam int ZERO_BIT = 0;
  localparam int TGT_BIT  = 1;
  localparam int CH_BASE  = 2;

  // route field position of the DMA selector
  localparam int DMA_LSB = 4;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_CLR_TGT,
    ACC_CLR_CH,
    ACC_NOCLR
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic [AW-1:0] a);
    acc_kind_e k;
    k = ACC_NONE;
    if (a == A_TGT || a == A_PTGT) k = ACC_CLR_TGT;
    else if (a == A_TGT_NC || a == A_PTGT_NC) k = ACC_NOCLR;
    else if (int'(a) >= CC_BASE && int'(a) < CCNC_BASE) k = ACC_CLR_CH;
    else if (int'(a) >= CCNC_BASE) k = ACC_NOCLR;
    return k;
  endfunction
endpackage

// File: rtl/tmr_evt_regif.sv
module tmr_evt_regif
  import tmr_evt_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 32,
  parameter int NS   = NCH + 2,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [NS-1:0]   raw_q,
  output logic [NS-1:0]   mask_q,
  output logic [NS-1:0]   mask_d,
  output logic [SELW-1:0] adc_sel_q,
  output logic [SELW-1:0] dma_sel_q,
  output logic [NS-1:0]   clr_vec,
  output logic [NS-1:0]   sw_set,
  output logic [DW-1:0]   bus_rdata
);
  logic          acc, wr_en, rd_en;
  logic [NS-1:0] side_clr;
  logic [DW-1:0] rd_val;
  acc_kind_e     kind;

  assign acc   = bus_sel && (bus_rd || bus_wr);
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && bus_rd;
  assign kind  = classify(bus_addr);

  // side-effect clears from data register accesses
  assign side_clr[ZERO_BIT] = acc && (kind == ACC_CLR_TGT);
  assign side_clr[TGT_BIT]  = acc && (kind == ACC_CLR_TGT);

  for (genvar c = 0; c < NCH; c++) begin : g_chclr
    localparam logic [AW-1:0] CC_A  = AW'(CC_BASE + c);
    localparam logic [AW-1:0] PCC_A = AW'(PCC_BASE + c);
    assign side_clr[CH_BASE+c] = acc && (bus_addr == CC_A || bus_addr == PCC_A);
  end

  always_comb begin
    clr_vec = side_clr;
    if (wr_en && bus_addr == A_ICLR) clr_vec = clr_vec | bus_wdata[NS-1:0];
    sw_set = '0;
    if (wr_en && bus_addr == A_ISET) sw_set = bus_wdata[NS-1:0];
    mask_d = mask_q;
    if (wr_en && bus_addr == A_MASK) mask_d = bus_wdata[NS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      adc_sel_q <= '1;
      dma_sel_q <= '1;
    end else begin
      mask_q <= mask_d;
      if (wr_en && bus_addr == A_ROUTE) begin
        adc_sel_q <= bus_wdata[SELW-1:0];
        dma_sel_q <= bus_wdata[DMA_LSB +: SELW];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_MASK:  rd_val[NS-1:0] = mask_q;
      A_RAW:   rd_val[NS-1:0] = raw_q;
      A_MIS:   rd_val[NS-1:0] = raw_q & mask_q;
      A_ROUTE: begin
        rd_val[SELW-1:0]          = adc_sel_q;
        rd_val[DMA_LSB +: SELW]   = dma_sel_q;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_en ? rd_val : '0;
  end

  // R13: without a read in the previous cycle the read bus idles at zero
  assert_rdata_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (bus_rdata == '0));
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
  import tmr_evt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int NS  = NCH + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_at_zero,
  input  logic           cnt_at_tgt,
  input  logic           tmr_start,
  input  logic [NCH-1:0] ch_evt,
  input  logic [NS-1:0]  clr_vec,
  input  logic [NS-1:0]  sw_set,
  output logic [NS-1:0]  raw_q,
  output logic [NS-1:0]  raw_d
);
  logic          zero_pend, tgt_pend;
  logic [NS-1:0] set_all;

  // zero/target flags take one extra cycle; a start never arms zero
  always_ff @(posedge clk) begin
    if (rst) begin
      zero_pend <= 1'b0;
      tgt_pend  <= 1'b0;
    end else begin
      zero_pend <= cnt_at_zero && !tmr_start;
      tgt_pend  <= cnt_at_tgt;
    end
  end

  assign set_all = {ch_evt, tgt_pend, zero_pend} | sw_set;
  // set wins over every clear source
  assign raw_d   = (raw_q & ~clr_vec) | set_all;

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_d;
  end

  assert_start_no_zero_R9: assert property (@(posedge clk) disable iff (rst)
    tmr_start |=> !zero_pend);

  assert_zero_delay_R7: assert property (@(posedge clk) disable iff (rst)
    zero_pend |=> raw_q[ZERO_BIT]);

  for (genvar i = 0; i < NS; i++) begin : g_chk
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
      set_all[i] |=> raw_q[i]);
    // covers R4, R5 and R10 clear paths
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !set_all[i]) |=> !raw_q[i]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_ch_same_edge_R8: assert property (@(posedge clk) disable iff (rst)
      ch_evt[c] |=> raw_q[CH_BASE+c]);
  end
endmodule

// File: rtl/tmr_evt_pulse.sv
module tmr_evt_pulse #(
  parameter int NS   = 6,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] sel,
  input  logic [NS-1:0]   vec_d,
  input  logic [NS-1:0]   vec_q,
  output logic            pulse
);
  logic sel_ok;
  assign sel_ok = (int'(sel) < NS);

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= sel_ok && vec_d[sel] && !vec_q[sel];
  end

  // a pulse always coincides with a status bit that just rose (R2, R3)
  assert_pulse_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ((vec_q & ~$past(vec_q)) != '0));
endmodule

// File: rtl/tmr_evt_router.sv
module tmr_evt_router
  import tmr_evt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_at_zero,
  input  logic           cnt_at_tgt,
  input  logic           tmr_start,
  input  logic [NCH-1:0] ch_evt,
  input  logic           bus_sel,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [4:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq,
  output logic           adc_trig,
  output logic           dma_req
);
  localparam int NS   = NCH + 2;
  localparam int SELW = 3;

  logic [NS-1:0]   raw_q, raw_d, mask_q, mask_d, clr_vec, sw_set;
  logic [SELW-1:0] adc_sel_q, dma_sel_q;

  tmr_evt_regif #(.NCH(NCH), .DW(DW), .NS(NS), .SELW(SELW)) u_regif (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .raw_q(raw_q), .mask_q(mask_q), .mask_d(mask_d),
    .adc_sel_q(adc_sel_q), .dma_sel_q(dma_sel_q),
    .clr_vec(clr_vec), .sw_set(sw_set), .bus_rdata(bus_rdata)
  );

  tmr_evt_status #(.NCH(NCH), .NS(NS)) u_status (
    .clk(clk), .rst(rst),
    .cnt_at_zero(cnt_at_zero), .cnt_at_tgt(cnt_at_tgt), .tmr_start(tmr_start),
    .ch_evt(ch_evt), .clr_vec(clr_vec), .sw_set(sw_set),
    .raw_q(raw_q), .raw_d(raw_d)
  );

  tmr_evt_pulse #(.NS(NS), .SELW(SELW)) u_adc (
    .clk(clk), .rst(rst), .sel(adc_sel_q),
    .vec_d(raw_d), .vec_q(raw_q), .pulse(adc_trig)
  );

  tmr_evt_pulse #(.NS(NS), .SELW(SELW)) u_dma (
    .clk(clk), .rst(rst), .sel(dma_sel_q),
    .vec_d(raw_d), .vec_q(raw_q), .pulse(dma_req)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw_d & mask_d);
  end

  logic nc_acc;
  assign nc_acc = bus_sel && (bus_rd || bus_wr) && (classify(bus_addr) == ACC_NOCLR);

  assert_irq_mask_R1: assert property (@(posedge clk) disable iff (rst)
    irq == |(raw_q & mask_q));

  assert_noclear_alias_R6: assert property (@(posedge clk) disable iff (rst)
    nc_acc |=> (($past(raw_q) & ~raw_q) == '0));
endmodule

// File: tb/tb_tmr_evt_router.sv
module tb_tmr_evt_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_at_zero = 0, cnt_at_tgt = 0, tmr_start = 0;
  logic [3:0]  ch_evt = '0;
  logic        bus_sel = 0, bus_rd = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, adc_trig, dma_req;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference model state
  bit [5:0]  m_st, m_mask;
  bit        m_zp, m_tp;
  bit [2:0]  m_adc, m_dma;
  bit [31:0] e_rd;
  bit        e_irq, e_adc, e_dma;

  always #10 clk = ~clk;

  tmr_evt_router dut (
    .clk(clk), .rst(rst), .cnt_at_zero(cnt_at_zero), .cnt_at_tgt(cnt_at_tgt),
    .tmr_start(tmr_start), .ch_evt(ch_evt), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .adc_trig(adc_trig), .dma_req(dma_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit rose(input bit [5:0] o, input bit [5:0] n, input bit [2:0] s);
    return (s < 3'd6) && n[s] && !o[s];
  endfunction

  task automatic model(input bit z, t, s, input bit [3:0] ch, input bit sel, rd, wr,
                       input bit [4:0] a, input bit [31:0] wd);
    bit [5:0] old, clr, set;
    bit acc;
    old = m_st;
    acc = sel && (rd || wr);
    clr = '0;
    if (acc && (a == 5'd8 || a == 5'd9)) clr |= 6'b000011;
    if (acc && a >= 5'd16 && a < 5'd24) clr[2 + a[1:0]] = 1'b1;
    if (sel && wr && a == 5'd3) clr |= wd[5:0];
    set = {ch, m_tp, m_zp};
    if (sel && wr && a == 5'd4) set |= wd[5:0];
    e_rd = '0;
    if (sel && rd) begin
      case (a)
        5'd0: e_rd = {26'd0, m_mask};
        5'd1: e_rd = {26'd0, m_st};
        5'd2: e_rd = {26'd0, m_st & m_mask};
        5'd5: e_rd = {25'd0, m_dma, 1'b0, m_adc};
        default: e_rd = '0;
      endcase
    end
    m_st = (old & ~clr) | set;
    m_zp = z && !s;
    m_tp = t;
    if (sel && wr && a == 5'd0) m_mask = wd[5:0];
    e_adc = rose(old, m_st, m_adc);
    e_dma = rose(old, m_st, m_dma);
    if (sel && wr && a == 5'd5) begin
      m_adc = wd[2:0];
      m_dma = wd[6:4];
    end
    e_irq = |(m_st & m_mask);
  endtask

  // one clock: drive at falling edge, model at rising edge, check at next falling edge
  task automatic step(input bit z, t, s, input bit [3:0] ch, input bit sel, rd, wr,
                      input bit [4:0] a, input bit [31:0] wd, input string tag);
    cnt_at_zero = z; cnt_at_tgt = t; tmr_start = s; ch_evt = ch;
    bus_sel = sel; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    model(z, t, s, ch, sel, rd, wr, a, wd);
    @(negedge clk);
    check("R1 irq", {31'd0, irq}, {31'd0, e_irq});
    check("R2 adc_trig", {31'd0, adc_trig}, {31'd0, e_adc});
    check("R3 dma_req", {31'd0, dma_req}, {31'd0, e_dma});
    check(tag, bus_rdata, e_rd);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 4'h0, 0, 0, 0, 5'd0, 32'd0, tag);
  endtask
  task automatic rd(input bit [4:0] a, input string tag);
    step(0, 0, 0, 4'h0, 1, 1, 0, a, 32'd0, tag);
  endtask
  task automatic wr(input bit [4:0] a, input bit [31:0] d, input string tag);
    step(0, 0, 0, 4'h0, 1, 0, 1, a, d, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] r;
    r = $urandom(32'd1234);
    m_st = '0; m_mask = '0; m_zp = 0; m_tp = 0; m_adc = 3'd7; m_dma = 3'd7;
    e_rd = '0; e_irq = 0; e_adc = 0; e_dma = 0;
    repeat (3) @(negedge clk);
    // reset state
    check("R13 reset rdata", bus_rdata, 32'd0);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    check("R2 reset adc", {31'd0, adc_trig}, 32'd0);
    rst = 1'b0;
    rd(5'd5, "R2 route reset value");
    idle("R13 idle after read");

    // R9: starting at zero does not raise the zero flag
    step(1, 0, 1, 4'h0, 0, 0, 0, 5'd0, 32'd0, "R9");
    idle("R9"); rd(5'd1, "R9 raw readback"); idle("R9");

    // R7: zero flag appears one edge later than the counter input
    wr(5'd0, 32'h3f, "R1 mask all");
    step(1, 0, 0, 4'h0, 0, 0, 0, 5'd0, 32'd0, "R7");
    rd(5'd1, "R7 not yet set"); rd(5'd1, "R7 now set");
    step(0, 1, 0, 4'h0, 0, 0, 0, 5'd0, 32'd0, "R7 tgt");
    rd(5'd1, "R7 tgt pending"); rd(5'd1, "R7 tgt set");

    // R6: no-clear aliases leave status untouched
    rd(5'd10, "R6"); wr(5'd11, 32'hffff, "R6"); rd(5'd1, "R6 readback");
    // R5: target access clears zero and target
    rd(5'd8, "R5"); rd(5'd1, "R5 readback");

    // R8 and R4: channel event, no-clear access, then clearing access
    step(0, 0, 0, 4'b0100, 0, 0, 0, 5'd0, 32'd0, "R8");
    rd(5'd1, "R8 readback");
    rd(5'd26, "R6 cc alias"); wr(5'd30, 32'd5, "R6 pcc alias"); rd(5'd1, "R6 readback");
    wr(5'd22, 32'd9, "R4 preload cc"); rd(5'd1, "R4 readback");

    // R11, R10 and R13 masked read
    wr(5'd4, 32'h2d, "R11"); rd(5'd1, "R11 readback");
    wr(5'd0, 32'h0c, "R13 mask"); rd(5'd2, "R13 masked"); rd(5'd0, "R13 mask read");
    wr(5'd3, 32'h24, "R10"); rd(5'd1, "R10 readback");
    wr(5'd3, 32'h3f, "R10 clear all"); rd(5'd2, "R1 irq low");

    // R12: event and side-effect clear on the same bit
    step(0, 0, 0, 4'b0001, 1, 1, 0, 5'd16, 32'd0, "R12");
    rd(5'd1, "R12 kept");
    step(0, 0, 0, 4'h0, 1, 0, 1, 5'd3, 32'h3f, "R12"); // clear all
    wr(5'd4, 32'h02, "R12 prep");
    step(0, 1, 0, 4'h0, 1, 0, 1, 5'd3, 32'h02, "R12 clr");
    step(0, 0, 0, 4'h0, 1, 1, 0, 5'd9, 32'd0, "R12 tgt vs ptgt");
    rd(5'd1, "R12 tgt kept");

    // R2/R3 routing: adc on channel 1 (bit 3), dma on target (bit 1)
    wr(5'd5, 32'h13, "R2 route"); wr(5'd3, 32'h3f, "R2 clr");
    step(0, 0, 0, 4'b0010, 0, 0, 0, 5'd0, 32'd0, "R2 pulse");
    step(0, 0, 0, 4'b0010, 0, 0, 0, 5'd0, 32'd0, "R2 no repeat");
    step(0, 1, 0, 4'h0, 0, 0, 0, 5'd0, 32'd0, "R3");
    idle("R3 pulse"); idle("R3 done");
    wr(5'd5, 32'h76, "R2 disable"); rd(5'd5, "R13 route read");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit [4:0] a;
      bit [31:0] d;
      bit s, rr, ww;
      d = $urandom;
      a = 5'($urandom_range(0, 31));
      if (a == 5'd3 && ($urandom % 4) != 0) d[5:0] = 6'($urandom % 4);
      if (a == 5'd5) d = {25'd0, 3'($urandom % 8), 1'b0, 3'($urandom % 8)};
      s  = ($urandom % 2) == 0;
      rr = ($urandom % 2) == 0;
      ww = ($urandom % 3) == 0;
      step(($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 16) == 0,
           4'(($urandom % 4) == 0 ? $urandom : 0), s, rr, ww, a, d, "R13 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule